// File: doc/BRIEF.md
# Synchronous Burst SRAM with Pipelined Deselect

This block models a single-port synchronous SRAM with a short burst engine and a small internal array. Address, write data, the three chip enables, two address strobes, the burst advance input and the write controls are all sampled on the rising clock edge. A burst begins when either strobe loads the external address. The access that follows is a read, a byte-masked write or a full-word write. While no strobe is active, later cycles walk the two low address bits through a four-beat sequence under control of the advance input.

Two static mode inputs choose the read path and the burst order. In pass-through mode, read data appears after the edge that sampled the command. In registered mode, a further output register adds one cycle. A deselect goes through the same drive pipeline as a read, so the data bus stays driven for one full cycle after the deselect is sampled. Output enable and sleep gate the drive asynchronously. Sleep also blocks new commands and keeps the array contents. The read port is a data vector plus a drive-enable flag, which stand in for a tri-state pad.

Top module: `sync_burst_sram`

## Requirements
- R1: The part counts as selected only when `en1_ni`=0, `en2_i`=1 and `en3_ni`=0. An accepted strobe that samples any other combination is a deselect: nothing is written, no read is performed, and the drive turns off on the same schedule as for any deselect.
- R2: Either strobe loads `addr_i` as the burst base. A controller-strobe start with `gw_ni`=0 or `bw_ni`=0 is a write. Every other accepted start is a read.
- R3: In a cycle with no accepted strobe inside an active burst, `adv_ni`=0 moves the 2-bit beat count forward before the access. `adv_ni`=1 repeats the access at the current address.
- R4: With `burst_ilv_i`=1, the low two address bits of beat n are base XOR n. With `burst_ilv_i`=0 they are (base + n) mod 4. The upper address bits never change within a burst.
- R5: With `pipe_mode_i`=0, read data and drive appear after the edge that sampled the read. With `pipe_mode_i`=1 they appear one edge later.
- R6: After a read, a deselect sampled at edge n keeps `rdata_oe_o` high, holding the last read data, until edge n+1. The drive turns off after edge n+1, in both read modes.
- R7: A write with `gw_ni`=0 stores all lanes, whatever `lane_en_ni` holds.
- R8: A write with `gw_ni`=1 and `bw_ni`=0 stores only the lanes whose `lane_en_ni` bit is 0. Lane g is `wdata_i[8g+7:8g]`. The other lanes keep their contents.
- R9: The processor strobe has no effect while `en1_ni`=1. When it does take effect, it wins over the controller strobe and always starts a read.
- R10: `oe_ni`=1 forces `rdata_oe_o` low with no clock edge. `rdata_o` is all zeros whenever `rdata_oe_o` is 0.
- R11: `sleep_i`=1 forces `rdata_oe_o` low at once. Commands are ignored at every edge where sleep is high, and at the first edge after it falls. The array contents are kept.
- R12: A new address can be loaded on every cycle. Back-to-back loads give one read result per cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| en1_ni | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2_i | input | 1 | Chip enable 2, active high |
| en3_ni | input | 1 | Chip enable 3, active low |
| strobe_p_ni | input | 1 | Processor address strobe, active low |
| strobe_c_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Full-word write, active low |
| bw_ni | input | 1 | Byte write, active low |
| lane_en_ni | input | LANES | Per-lane write enables, active low |
| pipe_mode_i | input | 1 | 1 = registered reads, 0 = pass-through reads |
| burst_ilv_i | input | 1 | 1 = interleaved order, 0 = linear order |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high, asynchronous |
| rdata_o | output | DW | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Read bus drive enable |

## Verification
The hardest case to reach is the window in which the drive outlives a deselect. To see it, a read must be followed at once by a deselect. The bench must then sample in the single cycle where the bus still carries the old word, and again in the cycle after, when it has gone quiet. The stimulus does this in both read modes. It ends a four-beat burst with a controller strobe while `en1_ni` is high, and it checks both cycles. It uses the same approach for the wake-up delay after sleep: a read issued at the release edge must leave no trace one edge later.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low address bits of a beat: XOR for interleaved, modular add for linear
  function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                         input logic [1:0] cnt,
                                         input logic       ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          en1_ni,
  input  logic          en2_i,
  input  logic          en3_ni,
  input  logic          strobe_p_ni,
  input  logic          strobe_c_ni,
  input  logic          adv_ni,
  input  logic          gw_ni,
  input  logic          bw_ni,
  input  logic          burst_ilv_i,
  input  logic          sleep_i,
  output op_e           op_o,
  output logic [AW-1:0] acc_addr_o
);

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          active_q, active_d;
  logic          sleep_q;

  logic awake, cs, p_start, c_start, wr_req;

  assign awake   = !sleep_i && !sleep_q;
  assign cs      = !en1_ni && en2_i && !en3_ni;
  assign p_start = awake && !strobe_p_ni && !en1_ni;
  assign c_start = awake && !p_start && !strobe_c_ni;
  assign wr_req  = !gw_ni || !bw_ni;

  always_comb begin
    op_o       = OP_NONE;
    base_d     = base_q;
    cnt_d      = cnt_q;
    active_d   = active_q;
    acc_addr_o = base_q;
    if (p_start || c_start) begin
      base_d     = addr_i;
      cnt_d      = 2'd0;
      active_d   = cs;
      acc_addr_o = addr_i;
      if (cs) op_o = (c_start && wr_req) ? OP_WRITE : OP_READ;
    end else if (awake && active_q) begin
      cnt_d      = cnt_q + {1'b0, !adv_ni};
      acc_addr_o = {base_q[AW-1:2], beat_lo(base_q[1:0], cnt_d, burst_ilv_i)};
      op_o       = wr_req ? OP_WRITE : OP_READ;
    end else begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      sleep_q  <= 1'b0;
    end else begin
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
      sleep_q  <= sleep_i;
    end
  end

  p_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((!strobe_p_ni && !en1_ni) || !strobe_c_ni) && !(en2_i && !en3_ni && !en1_ni))
      |-> op_o == OP_NONE);

  p_adv_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && awake && strobe_c_ni && (strobe_p_ni || en1_ni) && adv_ni)
      |=> $stable(cnt_q));

  p_proc_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en1_ni && strobe_c_ni && !active_q) |-> op_o == OP_NONE);

  p_sleep_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> op_o == OP_NONE);

  p_wake_delay_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_i) |-> op_o == OP_NONE);

endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             gw_ni,
  input  logic [LANES-1:0] lane_en_ni,
  output logic [DW-1:0]    rd_data_o
);

  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / LANES;

  logic [DW-1:0]    mem [DEPTH];
  logic [LANES-1:0] lane_we;
  logic [DW-1:0]    wmask;
  logic             we;

  assign we      = (op_i == OP_WRITE);
  assign lane_we = gw_ni ? ~lane_en_ni : {LANES{1'b1}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wmask[g*LW +: LW] = {LW{lane_we[g]}};
  end

  always_ff @(posedge clk_i) begin
    if (we) mem[addr_i] <= (mem[addr_i] & ~wmask) | (wdata_i & wmask);
  end

  // read register: output of the pass-through path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_data_o <= '0;
    else if (op_i == OP_READ)   rd_data_o <= mem[addr_i];
  end

  p_gw_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && !gw_ni) |=> mem[$past(addr_i)] == $past(wdata_i));

  p_lane_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && gw_ni && lane_en_ni[0])
      |=> mem[$past(addr_i)][LW-1:0] == $past(mem[addr_i][LW-1:0]));

endmodule

// File: rtl/sbs_outpipe.sv
module sbs_outpipe
  import sbs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic          pipe_mode_i,
  input  logic          oe_ni,
  input  logic          sleep_i,
  input  logic [DW-1:0] flow_data_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_oe_o
);

  logic          d1_q, d2_q;
  logic [DW-1:0] pipe_q;
  logic          drive_raw;
  logic [DW-1:0] data_sel;

  // deselect flows through the same two stages as a read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q   <= 1'b0;
      d2_q   <= 1'b0;
      pipe_q <= '0;
    end else begin
      d1_q <= (op_i == OP_READ);
      d2_q <= d1_q;
      if (d1_q) pipe_q <= flow_data_i;
    end
  end

  assign drive_raw  = pipe_mode_i ? d2_q : (d1_q || d2_q);
  assign data_sel   = pipe_mode_i ? pipe_q : flow_data_i;
  assign rdata_oe_o = drive_raw && !oe_ni && !sleep_i;
  assign rdata_o    = rdata_oe_o ? data_sel : '0;

  p_pipe_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_READ && pipe_mode_i) ##1 pipe_mode_i
      |=> (rdata_oe_o || oe_ni || sleep_i || !pipe_mode_i));

  p_flow_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_READ && !pipe_mode_i)
      |=> (rdata_oe_o || oe_ni || sleep_i || pipe_mode_i));

  p_dcd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_READ) ##1 (op_i != OP_READ && !pipe_mode_i)
      |=> (rdata_oe_o || oe_ni || sleep_i || pipe_mode_i));

  p_dcd_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_READ) ##1 (op_i != OP_READ) |=> !rdata_oe_o);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             en1_ni,
  input  logic             en2_i,
  input  logic             en3_ni,
  input  logic             strobe_p_ni,
  input  logic             strobe_c_ni,
  input  logic             adv_ni,
  input  logic             gw_ni,
  input  logic             bw_ni,
  input  logic [LANES-1:0] lane_en_ni,
  input  logic             pipe_mode_i,
  input  logic             burst_ilv_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rdata_oe_o
);

  op_e           op;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] flow_data;

  sbs_ctrl #(.AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .en1_ni      (en1_ni),
    .en2_i       (en2_i),
    .en3_ni      (en3_ni),
    .strobe_p_ni (strobe_p_ni),
    .strobe_c_ni (strobe_c_ni),
    .adv_ni      (adv_ni),
    .gw_ni       (gw_ni),
    .bw_ni       (bw_ni),
    .burst_ilv_i (burst_ilv_i),
    .sleep_i     (sleep_i),
    .op_o        (op),
    .acc_addr_o  (acc_addr)
  );

  sbs_array #(.AW(AW), .DW(DW), .LANES(LANES)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .addr_i     (acc_addr),
    .wdata_i    (wdata_i),
    .gw_ni      (gw_ni),
    .lane_en_ni (lane_en_ni),
    .rd_data_o  (flow_data)
  );

  sbs_outpipe #(.DW(DW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .pipe_mode_i (pipe_mode_i),
    .oe_ni       (oe_ni),
    .sleep_i     (sleep_i),
    .flow_data_i (flow_data),
    .rdata_o     (rdata_o),
    .rdata_oe_o  (rdata_oe_o)
  );

endmodule

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/100ps
module tb_sync_burst_sram;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [5:0]  addr_i;
  logic [31:0] wdata_i;
  logic        en1_ni, en2_i, en3_ni;
  logic        strobe_p_ni, strobe_c_ni, adv_ni, gw_ni, bw_ni;
  logic [3:0]  lane_en_ni;
  logic        pipe_mode_i, burst_ilv_i, oe_ni, sleep_i;
  logic [31:0] rdata_o;
  logic        rdata_oe_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  sync_burst_sram dut (.*);

  typedef struct packed {
    logic [5:0]  a;
    logic [31:0] d;
    logic [3:0]  ln;
    logic        gw;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{6'd5, 32'h11223344, 4'hF,    1'b1, 32'h11223344},
    '{6'd6, 32'hA5A50F0F, 4'hF,    1'b1, 32'hA5A50F0F},
    '{6'd5, 32'hFFFFFFFF, 4'b1110, 1'b0, 32'h112233FF},
    '{6'd6, 32'h00000000, 4'b0101, 1'b0, 32'h00A5000F},
    '{6'd7, 32'hDEADBEEF, 4'h0,    1'b1, 32'hDEADBEEF},
    '{6'd4, 32'hCAFEF00D, 4'hF,    1'b1, 32'hCAFEF00D},
    '{6'd7, 32'h00000000, 4'hF,    1'b0, 32'hDEADBEEF}
  };

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_on(input string tag, input logic [31:0] exp);
    chk(tag, {31'b0, rdata_oe_o}, 32'd1);
    chk(tag, rdata_o, exp);
  endtask

  task automatic chk_off(input string tag);
    chk(tag, {31'b0, rdata_oe_o}, 32'd0);
    chk(tag, rdata_o, 32'd0);
  endtask

  task automatic set_idle();
    addr_i = '0; wdata_i = '0;
    en1_ni = 1'b0; en2_i = 1'b1; en3_ni = 1'b0;
    strobe_p_ni = 1'b1; strobe_c_ni = 1'b1; adv_ni = 1'b1;
    gw_ni = 1'b1; bw_ni = 1'b1; lane_en_ni = 4'hF;
  endtask

  task automatic set_desel();
    set_idle();
    en1_ni = 1'b1; strobe_c_ni = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d,
                          input logic [3:0] ln, input logic gw);
    set_idle();
    strobe_c_ni = 1'b0; addr_i = a; wdata_i = d; lane_en_ni = ln;
    gw_ni = !gw; bw_ni = gw;
    tick();
    set_desel();
    tick();
    set_idle();
  endtask

  // registered-mode read: data one edge after the command
  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    set_idle();
    strobe_p_ni = 1'b0; addr_i = a;
    tick();
    set_desel();
    tick();
    chk_on(tag, exp);
    set_idle();
    tick();
    chk_off(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    set_idle();
    pipe_mode_i = 1'b1; burst_ilv_i = 1'b1; oe_ni = 1'b0; sleep_i = 1'b0;
    repeat (3) tick();
    chk_off("R10 reset");
    rst_ni = 1'b1;
    tick();

    // vector table: write through controller strobe, read back through processor strobe
    for (int i = 0; i < 7; i++) begin
      do_write(VECS[i].a, VECS[i].d, VECS[i].ln, VECS[i].gw);
      rd_chk(VECS[i].gw ? "R7 R2" : "R8 R2", VECS[i].a, VECS[i].exp);
    end

    // R4 interleaved burst, registered mode: 5,4,7,6
    set_idle(); strobe_p_ni = 1'b0; addr_i = 6'd5;
    tick();
    set_idle(); adv_ni = 1'b0;
    tick(); chk_on("R4 ilv beat0", 32'h112233FF);
    tick(); chk_on("R4 ilv beat1", 32'hCAFEF00D);
    tick(); chk_on("R4 ilv beat2", 32'hDEADBEEF);
    set_desel();
    tick(); chk_on("R4 ilv beat3", 32'h00A5000F);
    set_idle();
    tick(); chk_off("R6 pipe off");

    // R4 linear burst, pass-through mode: 6,7,4,5
    pipe_mode_i = 1'b0; burst_ilv_i = 1'b0;
    set_idle(); strobe_p_ni = 1'b0; addr_i = 6'd6;
    tick(); chk_on("R5 flow first", 32'h00A5000F);
    set_idle(); adv_ni = 1'b0;
    tick(); chk_on("R4 lin beat1", 32'hDEADBEEF);
    tick(); chk_on("R4 lin beat2", 32'hCAFEF00D);
    tick(); chk_on("R4 lin beat3", 32'h112233FF);
    set_desel();
    tick(); chk_on("R6 flow hold", 32'h112233FF);
    set_idle();
    tick(); chk_off("R6 flow off");
    pipe_mode_i = 1'b1; burst_ilv_i = 1'b1;
    tick();

    // R5 registered latency: nothing after the sampling edge
    set_idle(); strobe_p_ni = 1'b0; addr_i = 6'd7;
    tick(); chk_off("R5 pipe not yet");
    set_desel();
    tick(); chk_on("R5 pipe data", 32'hDEADBEEF);
    set_idle(); tick();

    // R3 suspend then advance
    set_idle(); strobe_p_ni = 1'b0; addr_i = 6'd4;
    tick();
    set_idle(); adv_ni = 1'b1;
    tick(); chk_on("R3 beat0", 32'hCAFEF00D);
    adv_ni = 1'b0;
    tick(); chk_on("R3 held", 32'hCAFEF00D);
    set_desel();
    tick(); chk_on("R3 advanced", 32'h112233FF);
    set_idle(); tick();

    // R12 loads on consecutive cycles
    set_idle(); strobe_p_ni = 1'b0; addr_i = 6'd7;
    tick();
    addr_i = 6'd5;
    tick(); chk_on("R12 load0", 32'hDEADBEEF);
    addr_i = 6'd6;
    tick(); chk_on("R12 load1", 32'h112233FF);
    set_desel();
    tick(); chk_on("R12 load2", 32'h00A5000F);
    set_idle(); tick();

    // R9 processor strobe ignored with en1 high: burst continues to 5
    set_idle(); strobe_p_ni = 1'b0; addr_i = 6'd4;
    tick();
    set_idle(); strobe_p_ni = 1'b0; en1_ni = 1'b1; addr_i = 6'd7; adv_ni = 1'b0;
    tick(); chk_on("R9 beat0", 32'hCAFEF00D);
    set_desel();
    tick(); chk_on("R9 ignored strobe", 32'h112233FF);
    set_idle(); tick();

    // R9 priority: both strobes with write control gives a read, no write
    set_idle(); strobe_p_ni = 1'b0; strobe_c_ni = 1'b0; gw_ni = 1'b0; addr_i = 6'd4;
    tick();
    set_desel();
    tick(); chk_on("R9 priority read", 32'hCAFEF00D);
    set_idle(); tick();
    rd_chk("R9 no write", 6'd4, 32'hCAFEF00D);

    // R1 deselect through bad enables
    set_idle(); strobe_p_ni = 1'b0; en2_i = 1'b0; addr_i = 6'd5;
    tick();
    set_idle();
    tick(); chk_off("R1 en2 low");
    set_idle(); strobe_c_ni = 1'b0; en3_ni = 1'b1; gw_ni = 1'b0; addr_i = 6'd5;
    tick();
    set_idle();
    tick(); chk_off("R1 en3 high");
    rd_chk("R1 no write", 6'd5, 32'h112233FF);

    // R10 / R11 asynchronous gating inside a driven window
    set_idle(); strobe_p_ni = 1'b0; addr_i = 6'd4;
    tick();
    set_desel();
    tick(); chk_on("R10 window", 32'hCAFEF00D);
    oe_ni = 1'b1; #0.2;
    chk_off("R10 oe high");
    oe_ni = 1'b0; #0.2;
    chk_on("R10 oe back", 32'hCAFEF00D);
    sleep_i = 1'b1; #0.2;
    chk_off("R11 async sleep");
    sleep_i = 1'b0;
    set_idle(); tick();
    tick();

    // R11 commands ignored in sleep and at the release edge, contents kept
    set_idle(); sleep_i = 1'b1;
    strobe_c_ni = 1'b0; gw_ni = 1'b0; addr_i = 6'd4; wdata_i = 32'h0;
    tick();
    tick();
    set_idle(); sleep_i = 1'b0; strobe_p_ni = 1'b0; addr_i = 6'd7;
    tick();
    set_idle(); strobe_p_ni = 1'b0; addr_i = 6'd4;
    tick(); chk_off("R11 wake edge ignored");
    set_desel();
    tick(); chk_on("R11 kept", 32'hCAFEF00D);
    set_idle(); tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule